// File: doc/BRIEF.md
# Panel Register Serial Master

This block gives a host simple read and write access to the 16-bit configuration registers of a display panel controller. The link has four wires: an active-low select, a serial clock, a data line toward the panel and a data line back from it. The host presents a register index, write data and a write-or-read flag, and raises a request strobe. The block then runs the whole access on the wire. When the access is over, it pulses a done flag and, for reads, updates the result register.

Each access is two 24-bit frames. The first frame selects the register: its upper byte carries the code 0x74 and the index sits in the low bits. The second frame moves the data. For a write it carries the code 0x76 above the 16-bit value. For a read it carries the code 0x77 above sixteen zero bits, and the panel returns the register contents on the incoming line during that frame. The bit rate is set by a half-period parameter counted in system clocks. Select settles for one half-period before the first bit and again after the last bit.

Top module: `panel_reg_spi_master`

## Requirements
- R1: While reset is high, and at every idle time after it, `spi_sel_n`, `spi_sclk` and `spi_mosi` are 1. After reset, `busy` and `done` are 0 and `rd_data` is 0.
- R2: A frame is exactly 24 serial clock pulses with select held low, sent most-significant bit first. On each bit the clock falls first and `spi_mosi` takes the bit value in that same low phase. The panel latches the bit on the rising clock.
- R3: Every clock low phase lasts exactly HALF_CYC system clocks, and so does every high phase. Select falls exactly HALF_CYC clocks before the first falling clock edge. Select rises HALF_CYC clocks after the last rising clock edge and stays high for HALF_CYC clocks before the next frame can start.
- R4: A write access sends frame {0x74, 8'h00, index} followed by frame {0x76, wdata[15:0]} (bits 23:16 hold the code).
- R5: A read access sends frame {0x74, 8'h00, index} followed by frame {0x77, 16'h0000}. `spi_miso` is sampled at the end of each low phase. `rd_data` becomes bits 15:0 of the 24 bits captured in the second frame; bits 23:16 are discarded.
- R6: `busy` is 1 from the cycle after a request is accepted until both frames are complete. It is 0 in the cycle where `done` is 1.
- R7: A request presented while `busy` is 1 is ignored: it produces no frame and no `done`, and it does not alter the access in progress.
- R8: `done` is a single-cycle pulse, exactly one per access. A write access leaves `rd_data` unchanged.
- R9: A request held high in the cycle where `done` pulses is accepted at once. `busy` is then 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe, taken when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_index | input | IDX_W | Register index |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| rd_data | output | 16 | Result of the last read |
| spi_sel_n | output | 1 | Panel select, active low |
| spi_sclk | output | 1 | Serial clock, rests high |
| spi_mosi | output | 1 | Serial data toward the panel |
| spi_miso | input | 1 | Serial data from the panel |

## Verification
Two events can fall in one cycle: the end of one access and the acceptance of the next request. The bench holds the request strobe high straight through an access, with new fields presented partway through. Because the first access is still busy, the new fields must not reach the wire. They must instead be taken in the very cycle where `done` pulses. The result is judged on three things: `done` appears alone while `busy` is low, `busy` is high again on the next cycle, and the frame scoreboard sees the first access's two frames followed directly by the second access's two frames, with no extra or missing frame.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;
    localparam int FRAME_W   = 24;
    localparam int DATA_W    = 16;
    localparam int PAYLOAD_W = FRAME_W - 8;

    localparam logic [7:0] CODE_INDEX = 8'h74;
    localparam logic [7:0] CODE_WRITE = 8'h76;
    localparam logic [7:0] CODE_READ  = 8'h77;

    typedef enum logic [2:0] {
        E_IDLE, E_SETUP, E_LOW, E_HIGH, E_HOLD
    } eng_state_t;

    typedef enum logic [1:0] {
        T_IDLE, T_INDEX, T_DATA
    } acc_state_t;
endpackage

// File: rtl/pspi_half_timer.sv
module pspi_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    generate
        if (HALF_CYC > 1) begin : g_spacing
            assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pspi_frame_engine.sv
module pspi_frame_engine
    import panel_spi_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               spi_miso,
    output logic               spi_sel_n,
    output logic               spi_sclk,
    output logic               spi_mosi,
    output logic               frame_done,
    output logic [DATA_W-1:0]  rx_word
);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    typedef struct packed {
        eng_state_t         st;
        logic [FRAME_W-1:0] shift;
        logic [DATA_W-1:0]  rx;
        logic [BW-1:0]      bitn;
        logic               sel_n;
        logic               sclk;
        logic               mosi;
        logic               fdone;
    } eng_regs_t;

    eng_regs_t r_d, r_q;
    logic      tick;

    pspi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (r_q.st != E_IDLE),
        .tick (tick)
    );

    always_comb begin
        r_d       = r_q;
        r_d.fdone = 1'b0;
        unique case (r_q.st)
            E_IDLE: begin
                r_d.sel_n = 1'b1;
                r_d.sclk  = 1'b1;
                r_d.mosi  = 1'b1;
                if (start) begin
                    r_d.shift = frame;
                    r_d.bitn  = LAST_BIT;
                    r_d.sel_n = 1'b0;
                    r_d.st    = E_SETUP;
                end
            end
            E_SETUP: if (tick) begin
                r_d.sclk = 1'b0;
                r_d.mosi = r_q.shift[FRAME_W-1];
                r_d.st   = E_LOW;
            end
            E_LOW: if (tick) begin
                r_d.rx   = {r_q.rx[DATA_W-2:0], spi_miso};
                r_d.sclk = 1'b1;
                r_d.st   = E_HIGH;
            end
            E_HIGH: if (tick) begin
                if (r_q.bitn == '0) begin
                    r_d.sel_n = 1'b1;
                    r_d.st    = E_HOLD;
                end else begin
                    r_d.bitn  = r_q.bitn - 1'b1;
                    r_d.shift = {r_q.shift[FRAME_W-2:0], 1'b0};
                    r_d.sclk  = 1'b0;
                    r_d.mosi  = r_q.shift[FRAME_W-2];
                    r_d.st    = E_LOW;
                end
            end
            E_HOLD: if (tick) begin
                r_d.mosi  = 1'b1;
                r_d.fdone = 1'b1;
                r_d.st    = E_IDLE;
            end
            default: r_d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= E_IDLE;
            r_q.shift <= '0;
            r_q.rx    <= '0;
            r_q.bitn  <= '0;
            r_q.sel_n <= 1'b1;
            r_q.sclk  <= 1'b1;
            r_q.mosi  <= 1'b1;
            r_q.fdone <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_sel_n  = r_q.sel_n;
    assign spi_sclk   = r_q.sclk;
    assign spi_mosi   = r_q.mosi;
    assign frame_done = r_q.fdone;
    assign rx_word    = r_q.rx;

    // R2: clock rests high whenever the panel is not selected
    assert_sclk_high_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        spi_sel_n |-> spi_sclk);

    // R2: data only moves during a low clock phase inside a frame
    assert_mosi_still_clk_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!spi_sel_n && $past(!spi_sel_n) && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R3: a frame only reports completion after select has been released
    assert_done_after_release_R3: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (spi_sel_n && $past(spi_sel_n)));
endmodule

// File: rtl/panel_reg_spi_master.sv
module panel_reg_spi_master
    import panel_spi_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic [15:0]      req_wdata,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             spi_sel_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    typedef struct packed {
        acc_state_t        st;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rd;
        logic              done;
    } acc_regs_t;

    acc_regs_t          a_d, a_q;
    logic               eng_start;
    logic [FRAME_W-1:0] eng_frame;
    logic               eng_done;
    logic [DATA_W-1:0]  eng_rx;

    always_comb begin
        a_d       = a_q;
        a_d.done  = 1'b0;
        eng_start = 1'b0;
        eng_frame = '0;
        unique case (a_q.st)
            T_IDLE: if (req_valid) begin
                a_d.wr    = req_write;
                a_d.idx   = req_index;
                a_d.wdata = req_wdata;
                a_d.st    = T_INDEX;
                eng_start = 1'b1;
                eng_frame = {CODE_INDEX, PAYLOAD_W'(req_index)};
            end
            T_INDEX: if (eng_done) begin
                eng_start = 1'b1;
                eng_frame = a_q.wr ? {CODE_WRITE, PAYLOAD_W'(a_q.wdata)}
                                   : {CODE_READ, {PAYLOAD_W{1'b0}}};
                a_d.st    = T_DATA;
            end
            T_DATA: if (eng_done) begin
                if (!a_q.wr) a_d.rd = eng_rx;
                a_d.done = 1'b1;
                a_d.st   = T_IDLE;
            end
            default: a_d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q.st    <= T_IDLE;
            a_q.wr    <= 1'b0;
            a_q.idx   <= '0;
            a_q.wdata <= '0;
            a_q.rd    <= '0;
            a_q.done  <= 1'b0;
        end else begin
            a_q <= a_d;
        end
    end

    pspi_frame_engine #(.HALF_CYC(HALF_CYC)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .frame      (eng_frame),
        .spi_miso   (spi_miso),
        .spi_sel_n  (spi_sel_n),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .frame_done (eng_done),
        .rx_word    (eng_rx)
    );

    assign busy    = (a_q.st != T_IDLE);
    assign done    = a_q.done;
    assign rd_data = a_q.rd;

    // R8: completion is flagged for one cycle only
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: completion and busy never overlap
    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: latched request fields are frozen for the whole access
    assert_fields_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(a_q.idx) && $stable(a_q.wr) && $stable(a_q.wdata)));

    // R8: a write completion leaves the read result untouched
    assert_write_keeps_rd_R8: assert property (@(posedge clk) disable iff (rst)
        (done && a_q.wr) |-> $stable(rd_data));
endmodule

// File: tb/panel_reg_spi_master_tb.sv
module panel_reg_spi_master_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_index = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic        spi_sel_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [23:0] exp_frames[$];
    logic [23:0] resp_q[$];
    logic [15:0] exp_rd[$];
    logic [15:0] model_rd = '0;

    always #5 clk = ~clk;

    panel_reg_spi_master #(.HALF_CYC(HALF), .IDX_W(8)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .spi_sel_n(spi_sel_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Panel model: returns queued response words, captures frames
    logic [23:0] cur_resp = '0;
    logic [23:0] cap = '0;
    int          bi = 23;
    int          nb = 0;
    logic [23:0] e_frame;

    always @(negedge spi_sel_n) begin
        cur_resp = (resp_q.size() != 0) ? resp_q.pop_front() : 24'h0;
        bi = 23;
        nb = 0;
        cap = '0;
    end
    always @(negedge spi_sclk) if (spi_sel_n === 1'b0) begin
        spi_miso <= cur_resp[bi];
        bi--;
    end
    always @(posedge spi_sclk) if (spi_sel_n === 1'b0) begin
        cap = {cap[22:0], spi_mosi};
        nb++;
    end
    always @(posedge spi_sel_n) if (rst === 1'b0 && nb != 0) begin
        check(nb == 24, "R2 clock pulses per frame", nb, 24);
        if (exp_frames.size() == 0)
            check(1'b0, "R7 unexpected frame on wire", cap, 0);
        else begin
            e_frame = exp_frames.pop_front();
            check(cap == e_frame, "R4/R5 frame content", cap, e_frame);
        end
        nb = 0;
    end

    // Timing and completion monitor, sampled away from the active edge
    int   lowlen = 0, setlen = 0;
    bit   first_pend = 1'b1;
    logic prev_done = 1'b0;
    logic [15:0] e_rd;

    always @(negedge clk) if (!rst) begin
        if (!spi_sclk) lowlen++;
        else begin
            if (lowlen != 0) check(lowlen == HALF, "R3 clock low width", lowlen, HALF);
            lowlen = 0;
        end
        if (spi_sel_n) begin
            first_pend = 1'b1;
            setlen = 0;
            check(spi_sclk === 1'b1, "R2 clock high while deselected", spi_sclk, 1);
        end else if (first_pend) begin
            if (spi_sclk) setlen++;
            else begin
                check(setlen == HALF, "R3 select setup", setlen, HALF);
                first_pend = 1'b0;
            end
        end
        if (done) begin
            check(!busy, "R6 busy low during done", busy, 0);
            check(!prev_done, "R8 done single cycle", prev_done, 0);
            if (exp_rd.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
            else begin
                e_rd = exp_rd.pop_front();
                check(rd_data == e_rd, "R5/R8 rd_data at done", rd_data, e_rd);
            end
        end
        prev_done = done;
    end

    task automatic expect_access(input bit wr, input logic [7:0] idx,
                                 input logic [15:0] wd, input logic [23:0] resp);
        exp_frames.push_back({8'h74, 8'h00, idx});
        exp_frames.push_back(wr ? {8'h76, wd} : {8'h77, 16'h0000});
        resp_q.push_back(24'h5A5A5A);
        resp_q.push_back(resp);
        if (!wr) model_rd = resp[15:0];
        exp_rd.push_back(model_rd);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic access(input bit wr, input logic [7:0] idx,
                          input logic [15:0] wd, input logic [23:0] resp);
        @(negedge clk);
        while (busy) @(negedge clk);
        expect_access(wr, idx, wd, resp);
        req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R6 busy after accept", busy, 1);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({spi_sel_n, spi_sclk, spi_mosi} == 3'b111, "R1 pins high in reset",
              {spi_sel_n, spi_sclk, spi_mosi}, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        check({spi_sel_n, spi_sclk, spi_mosi} == 3'b111, "R1 pins idle after reset",
              {spi_sel_n, spi_sclk, spi_mosi}, 3'b111);
        check(busy == 0 && done == 0, "R1 busy/done low", {busy, done}, 0);
        check(rd_data == 16'h0, "R1 rd_data cleared", rd_data, 0);

        access(1'b1, 8'h07, 16'h0015, 24'h0);      // R4 write
        access(1'b0, 8'h00, 16'h0,    24'hA50139); // R5 read, upper byte dropped
        access(1'b1, 8'h13, 16'hFFFF, 24'hFFFFFF); // R8 write keeps rd_data
        check(rd_data == 16'h0139, "R8 rd_data kept after write", rd_data, 16'h0139);
        access(1'b0, 8'hFF, 16'h0,    24'hFFFFFF); // R5 all ones
        access(1'b0, 8'h48, 16'h0,    24'h008001); // R5 edge bits

        // R7: request pulsed mid-access is ignored
        @(negedge clk);
        expect_access(1'b1, 8'h20, 16'h1234, 24'h0);
        req_valid = 1'b1; req_write = 1'b1; req_index = 8'h20; req_wdata = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (150) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_index = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        check(!busy, "R7 no access started by ignored request", busy, 0);
        check(exp_frames.size() == 0, "R7 frame count after ignored request", exp_frames.size(), 0);

        // R9: request held through the done cycle
        @(negedge clk);
        expect_access(1'b1, 8'h46, 16'hEF00, 24'h0);
        expect_access(1'b0, 8'h21, 16'h0, 24'h12C3A5);
        req_valid = 1'b1; req_write = 1'b1; req_index = 8'h46; req_wdata = 16'hEF00;
        @(negedge clk);
        check(busy == 1'b1, "R6 busy after accept", busy, 1);
        req_write = 1'b0; req_index = 8'h21; req_wdata = 16'h0000;
        wait_done();
        @(negedge clk);
        check(busy == 1'b1, "R9 back-to-back accepted in done cycle", busy, 1);
        req_valid = 1'b0;
        wait_done();
        check(rd_data == 16'hC3A5, "R9 second access result", rd_data, 16'hC3A5);

        repeat (20) @(negedge clk);
        check(exp_frames.size() == 0, "R7 all expected frames seen", exp_frames.size(), 0);
        check(exp_rd.size() == 0, "R8 one done per access", exp_rd.size(), 0);
        check({spi_sel_n, spi_sclk, spi_mosi} == 3'b111, "R1 pins idle at end",
              {spi_sel_n, spi_sclk, spi_mosi}, 3'b111);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule